// File: doc/BRIEF.md
# Indexed Real-Time Clock Register File

This block is the register side of a CMOS-style real-time clock. Software first writes a register number through an index strobe, then reads or writes that register through data strobes. Ten byte locations hold the time-of-day and calendar bytes, which are loaded at reset from parameters. Four status registers (A to D) follow them. The block does not advance the time. It only stores the bytes and gives them back.

A divider on the system clock gives a periodic interrupt. The divider is controlled by a small state machine with two states. In `TK_HALT` the divider is held at zero. In `TK_RUN` it counts. The transition START (`TK_HALT` to `TK_RUN`) is taken when the periodic-enable bit (bit 6 of status B) is set. The transition STOP (`TK_RUN` to `TK_HALT`) is taken when that bit is clear. The transition WRAP (`TK_RUN` to `TK_RUN`) is taken when the divider expires, and it emits a one-cycle pulse. Any access the block cannot honour gives a one-cycle error pulse. The access then has no other effect.

Only one strobe is acted on per cycle. The index strobe wins over a data write, and a data write wins over a data read.

Top module: `rtc_regfile`

## Requirements
- R1: An index write with `wdata` from 0x00 to 0x0D stores it as the current index. A larger value leaves the index unchanged and raises `err` for one cycle, in the cycle after the strobe.
- R2: Indices 0x00 to 0x09 are plain bytes: a data write stores `wdata`, and a later data read returns it unchanged. `rdata` is registered and holds the new value from the cycle after the read strobe.
- R3: At reset the bytes load as follows. Index 0 holds seconds, 2 minutes, 4 hours, 6 weekday, 7 day of month, 8 month and 9 year. Indices 1, 3 and 5 are 0. Weekday is stored as the 0-based parameter plus 1, so 1 means Sunday. Month is stored as the 0-based parameter plus 1, so it runs 1 to 12. When `YEAR_BCD` is 1, the year is stored as two BCD digits of (year mod 100).
- R4: Status A (index 0x0A) resets to 0x26. A data write of exactly 0x26 is stored. Any other value raises `err` and leaves A unchanged.
- R5: Each data read of status A inverts bit 7 (update-in-progress) and returns the inverted value, so successive reads alternate that bit.
- R6: Status B (index 0x0B) resets to 0x46. A write is stored only if bits 2 and 1 are set and bits 7, 5, 4 and 0 are clear. Bits 6 and 3 are free. Any other write raises `err` and leaves B unchanged.
- R7: Reads of status C (0x0C) and D (0x0D) return 0x00. Writes to them raise `err`.
- R8: While bit 6 of status B is set, `irq` pulses high for one cycle every `DIV` cycles. While that bit is clear, `irq` stays low.
- R9: Writing B with bit 6 set while the divider is already running does not restart the divider. After bit 6 goes from clear to set, the first pulse comes `DIV`+1 cycles after the clock edge that stored the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_we | input | 1 | Index write strobe |
| dat_we | input | 1 | Data write strobe to the indexed register |
| dat_re | input | 1 | Data read strobe from the indexed register |
| wdata | input | 8 | Write data for either strobe |
| rdata | output | 8 | Registered read data |
| err | output | 1 | One-cycle pulse on a rejected access |
| irq | output | 1 | One-cycle periodic interrupt pulse |

## Verification
`rdata` and `err` are registered, so both are due in the cycle after the strobe's clock edge. The bench raises each strobe for one cycle between falling edges and samples on the falling edge that follows, which lands exactly in that cycle. Interrupt timing is measured in falling edges counted from the edge that stored a status B write. The first pulse is expected `DIV`+1 edges later, and each pulse after it `DIV` edges after the one before. To show that disabling has effect, a window several periods long is watched for any pulse.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam logic [3:0] IDX_STAT_A = 4'hA;
    localparam logic [3:0] IDX_STAT_B = 4'hB;
    localparam logic [3:0] IDX_STAT_C = 4'hC;
    localparam logic [3:0] IDX_LAST   = 4'hD;
    localparam logic [7:0] A_RESET    = 8'h26;
    localparam logic [7:0] A_UIP      = 8'h80;
    localparam logic [7:0] B_RESET    = 8'h46;
    localparam logic [7:0] B_PIE      = 8'h40;
    localparam logic [7:0] B_SQWE     = 8'h08;
    localparam logic [7:0] B_FIXED    = 8'h06;

    typedef enum logic {TK_HALT, TK_RUN} tick_state_e;

    function automatic logic [7:0] to_bcd(input int unsigned v);
        int unsigned r;
        r = v % 100;
        return {4'(r / 10), 4'(r % 10)};
    endfunction
endpackage

// File: rtl/rtc_tick.sv
module rtc_tick #(
    parameter int unsigned DIV = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic pulse
);
    import rtc_pkg::*;

    localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    tick_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TK_HALT: if (enable)  state_d = TK_RUN;   // START
            TK_RUN:  if (!enable) state_d = TK_HALT;  // STOP (WRAP stays)
            default: state_d = TK_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TK_HALT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            unique case (state_q)
                TK_HALT: cnt_q <= '0;
                TK_RUN: begin
                    if (!enable) begin
                        cnt_q <= '0;
                    end else if (cnt_q == LAST) begin
                        cnt_q <= '0;
                        pulse <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(enable));                                      // R8
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);                                             // R8
    AST_HALT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TK_HALT) |-> (cnt_q == '0));                       // R9
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs #(
    parameter int unsigned INIT_SEC  = 30,
    parameter int unsigned INIT_MIN  = 45,
    parameter int unsigned INIT_HOUR = 13,
    parameter int unsigned INIT_WDAY = 2,
    parameter int unsigned INIT_MDAY = 15,
    parameter int unsigned INIT_MON  = 6,
    parameter int unsigned INIT_YEAR = 124,
    parameter bit          YEAR_BCD  = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_we,
    input  logic       dat_we,
    input  logic       dat_re,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       err,
    output logic       pie
);
    import rtc_pkg::*;

    localparam int unsigned NCAL = 10;

    function automatic logic [7:0] init_byte(input int unsigned i);
        case (i)
            0:       return 8'(INIT_SEC);
            2:       return 8'(INIT_MIN);
            4:       return 8'(INIT_HOUR);
            6:       return 8'(INIT_WDAY + 1);
            7:       return 8'(INIT_MDAY);
            8:       return 8'(INIT_MON + 1);
            9:       return YEAR_BCD ? to_bcd(INIT_YEAR) : 8'(INIT_YEAR);
            default: return 8'h00;
        endcase
    endfunction

    logic [3:0] idx_q;
    logic [7:0] cal_q [NCAL];
    logic [7:0] stat_a, stat_b;
    logic       rd_only;

    assign pie     = stat_b[6];
    assign rd_only = dat_re && !idx_we && !dat_we;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            stat_a <= A_RESET;
            stat_b <= B_RESET;
            rdata  <= '0;
            err    <= 1'b0;
            for (int i = 0; i < NCAL; i++) cal_q[i] <= init_byte(i);
        end else begin
            err <= 1'b0;
            if (idx_we) begin
                if (wdata <= {4'h0, IDX_LAST}) idx_q <= wdata[3:0];
                else                           err   <= 1'b1;
            end else if (dat_we) begin
                if (idx_q < IDX_STAT_A) begin
                    cal_q[idx_q] <= wdata;
                end else begin
                    case (idx_q)
                        IDX_STAT_A: begin
                            if (wdata == A_RESET) stat_a <= wdata;
                            else                  err    <= 1'b1;
                        end
                        IDX_STAT_B: begin
                            if ((wdata & ~(B_PIE | B_SQWE)) == B_FIXED) stat_b <= wdata;
                            else                                        err    <= 1'b1;
                        end
                        default: err <= 1'b1;
                    endcase
                end
            end else if (dat_re) begin
                if (idx_q < IDX_STAT_A) begin
                    rdata <= cal_q[idx_q];
                end else begin
                    case (idx_q)
                        IDX_STAT_A: begin
                            stat_a <= stat_a ^ A_UIP;
                            rdata  <= stat_a ^ A_UIP;
                        end
                        IDX_STAT_B: rdata <= stat_b;
                        default:    rdata <= 8'h00;
                    endcase
                end
            end
        end
    end

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IDX_LAST);                                            // R1
    AST_BAD_IDX_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_we && wdata > {4'h0, IDX_LAST}) |=> (err && $stable(idx_q))); // R1
    AST_ERR_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(idx_we || dat_we));                              // R4
    AST_B_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_b & B_FIXED) == B_FIXED);                                // R6
    AST_UIP_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && idx_q == IDX_STAT_A) |=> (rdata[7] != $past(stat_a[7]))); // R5
    AST_CD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && idx_q >= IDX_STAT_C) |=> (rdata == 8'h00));       // R7
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile #(
    parameter int unsigned DIV       = 1024,
    parameter int unsigned INIT_SEC  = 30,
    parameter int unsigned INIT_MIN  = 45,
    parameter int unsigned INIT_HOUR = 13,
    parameter int unsigned INIT_WDAY = 2,
    parameter int unsigned INIT_MDAY = 15,
    parameter int unsigned INIT_MON  = 6,
    parameter int unsigned INIT_YEAR = 124,
    parameter bit          YEAR_BCD  = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_we,
    input  logic       dat_we,
    input  logic       dat_re,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       err,
    output logic       irq
);
    logic pie;

    rtc_regs #(
        .INIT_SEC(INIT_SEC), .INIT_MIN(INIT_MIN), .INIT_HOUR(INIT_HOUR),
        .INIT_WDAY(INIT_WDAY), .INIT_MDAY(INIT_MDAY), .INIT_MON(INIT_MON),
        .INIT_YEAR(INIT_YEAR), .YEAR_BCD(YEAR_BCD)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .dat_we(dat_we),
        .dat_re(dat_re), .wdata(wdata), .rdata(rdata), .err(err), .pie(pie)
    );

    rtc_tick #(.DIV(DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .enable(pie), .pulse(irq)
    );
endmodule

// File: tb/test_rtc_regfile.sv
module test_rtc_regfile;
    localparam int unsigned DIV = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idx_we = 1'b0, dat_we = 1'b0, dat_re = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       err, irq;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    rtc_regfile #(.DIV(DIV), .YEAR_BCD(1'b1)) i_rtc_regfile (
        .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .dat_we(dat_we),
        .dat_re(dat_re), .wdata(wdata), .rdata(rdata), .err(err), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic strobe(input bit i, input bit w, input bit r, input logic [7:0] d);
        @(negedge clk);
        idx_we = i; dat_we = w; dat_re = r; wdata = d;
        @(negedge clk);
        idx_we = 0; dat_we = 0; dat_re = 0;
    endtask

    task automatic rd(input logic [7:0] idx, input logic [7:0] exp, input string req);
        strobe(1, 0, 0, idx);
        strobe(0, 0, 1, 8'h00);
        check(req, rdata, exp);
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] d, input bit exp_err, input string req);
        strobe(1, 0, 0, idx);
        strobe(0, 1, 0, d);
        check(req, err, exp_err);
    endtask

    task automatic t_reset_values;
        check("R8 reset irq", irq, 0);
        rd(8'h00, 8'd30, "R3 sec");
        rd(8'h01, 8'h00, "R3 alarm");
        rd(8'h02, 8'd45, "R3 min");
        rd(8'h04, 8'd13, "R3 hour");
        rd(8'h06, 8'd3,  "R3 weekday");
        rd(8'h07, 8'd15, "R3 mday");
        rd(8'h08, 8'd7,  "R3 month");
        rd(8'h09, 8'h24, "R3 bcd year");
        rd(8'h0B, 8'h46, "R6 B reset");
    endtask

    task automatic t_storage;
        wr(8'h03, 8'h5A, 0, "R2 write ok");
        rd(8'h03, 8'h5A, "R2 readback");
        wr(8'h09, 8'hC3, 0, "R2 write ok");
        strobe(0, 0, 1, 8'h00);
        check("R2 readback", rdata, 8'hC3);
    endtask

    task automatic t_index;
        strobe(1, 0, 0, 8'h03);
        strobe(1, 0, 0, 8'h0E);
        check("R1 err", err, 1);
        strobe(0, 0, 0, 8'h00);
        check("R1 err clears", err, 0);
        strobe(0, 0, 1, 8'h00);
        check("R1 index kept", rdata, 8'h5A);
        strobe(1, 0, 0, 8'h0D);
        check("R1 max ok", err, 0);
    endtask

    task automatic t_stat_a;
        rd(8'h0A, 8'hA6, "R5 first read");
        strobe(0, 0, 1, 8'h00);
        check("R5 second read", rdata, 8'h26);
        strobe(0, 0, 1, 8'h00);
        check("R5 third read", rdata, 8'hA6);
        strobe(0, 1, 0, 8'h20);
        check("R4 bad write err", err, 1);
        strobe(0, 0, 1, 8'h00);
        check("R4 unchanged", rdata, 8'h26);
        strobe(0, 0, 1, 8'h00);
        strobe(0, 1, 0, 8'h26);
        check("R4 good write", err, 0);
        strobe(0, 0, 1, 8'h00);
        check("R4 stored", rdata, 8'hA6);
    endtask

    task automatic t_stat_b;
        wr(8'h0B, 8'h4E, 0, "R6 sqwe ok");
        strobe(0, 0, 1, 8'h00);
        check("R6 readback", rdata, 8'h4E);
        strobe(0, 1, 0, 8'h40);
        check("R6 fixed bits err", err, 1);
        strobe(0, 1, 0, 8'hC6);
        check("R6 bit7 err", err, 1);
        strobe(0, 0, 1, 8'h00);
        check("R6 unchanged", rdata, 8'h4E);
        wr(8'h0B, 8'h46, 0, "R6 restore");
    endtask

    task automatic t_stat_cd;
        rd(8'h0C, 8'h00, "R7 C read");
        rd(8'h0D, 8'h00, "R7 D read");
        wr(8'h0C, 8'hFF, 1, "R7 C write err");
        wr(8'h0D, 8'h11, 1, "R7 D write err");
        strobe(0, 0, 1, 8'h00);
        check("R7 D still zero", rdata, 8'h00);
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!irq && n < 4 * DIV);
    endtask

    task automatic t_irq;
        int n;
        int seen;
        wait_irq(n);
        check("R8 pulse present", irq, 1);
        @(negedge clk);
        check("R8 one cycle", irq, 0);
        wait_irq(n);
        check("R8 period", n, DIV - 1);
        strobe(1, 0, 0, 8'h0B);
        strobe(0, 1, 0, 8'h06);
        seen = 0;
        for (int k = 0; k < 5 * DIV; k++) begin
            @(negedge clk);
            if (irq) seen++;
        end
        check("R8 disabled quiet", seen, 0);
        strobe(0, 1, 0, 8'h46);
        wait_irq(n);
        check("R9 first pulse delay", n, DIV + 1);
        repeat (3) @(negedge clk);
        strobe(0, 1, 0, 8'h46);
        wait_irq(n);
        check("R9 no restart", n + 5, DIV);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_values();
        t_storage();
        t_index();
        t_stat_a();
        t_stat_b();
        t_stat_cd();
        t_irq();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule